// File: doc/BRIEF.md
# SIMD Lane Divergence Mask Unit

This unit governs which lanes of an eight-wide SIMD group are allowed to execute while all of them follow a single instruction stream. The group cannot jump to different places when lanes disagree on a conditional. Instead, the unit narrows an active-lane mask so that the taken side runs first with only the agreeing lanes enabled. It then flips to the remaining lanes of the enclosing mask for the other side. At the join point it brings back the mask that was in force before the conditional.

The sequencer driving the group pulses one of three plain control strobes per instruction: open-conditional (with each lane's condition bit presented alongside), switch-to-other-side, and close-conditional. The saved masks live on a small last-in-first-out stack, so conditionals may nest up to the stack depth. A skip indication tells the sequencer that no lane is enabled on the current side, so that side can be jumped over. Misuse (nesting too deep, closing or switching with nothing open, or more than one strobe in a cycle) is ignored and latched into a sticky error flag. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `divergence_mask_unit`

## Requirements
- R1: After reset the active mask has all 8 lanes set (0xFF), the nesting depth is 0, the skip flag is low and the error flag is low.
- R2: A lone open-conditional strobe with depth below 4 sets the mask to the previous mask ANDed with the lane condition bits (bit i = lane i), so condition bits of already-disabled lanes have no effect, and raises the depth by one.
- R3: A lone switch strobe with depth above 0 sets the mask to the mask that was in force when the innermost open conditional was opened, ANDed with the inverse of that conditional's condition bits; the depth is unchanged and a second switch gives the same mask again.
- R4: A lone close strobe with depth above 0 restores the mask that was in force just before the matching open-conditional and lowers the depth by one.
- R5: The skip flag is high exactly when the active mask is all zeros; this can only happen while at least one conditional is open.
- R6: Conditionals nest up to 4 deep; each inner conditional narrows, switches and restores relative to the mask of the conditional enclosing it.
- R7: An open-conditional strobe at depth 4 changes neither mask nor depth and sets the error flag.
- R8: A switch or close strobe at depth 0 changes neither mask nor depth and sets the error flag.
- R9: A cycle with two or more strobes high is ignored as a whole (mask and depth unchanged) and sets the error flag.
- R10: Once set, the error flag stays high through any later strobes until reset.
- R11: In a cycle with no strobe, mask, depth and skip hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_strobe | input | 1 | Open a conditional using lane_cond |
| else_strobe | input | 1 | Switch to the other side of the innermost conditional |
| endif_strobe | input | 1 | Close the innermost conditional |
| lane_cond | input | 8 | Per-lane condition bits, sampled with br_strobe |
| active_mask | output | 8 | Lanes currently enabled to execute |
| skip_path | output | 1 | High when no lane is enabled on the current side |
| nest_depth | output | 3 | Number of open conditionals (0 to 4) |
| err_flag | output | 1 | Sticky misuse indication |

## Verification
On every cycle the assertions check the narrowing rule for legal open-conditionals, that idle cycles hold state, that overflow and multi-strobe misuse leave the mask alone while raising the error flag, that the error flag never drops, that the depth stays in range, and that an empty stack always means a full mask. What only the bench scenarios show is the restoring side: that the switch and close strobes recover exactly the saved masks across a full sweep of condition patterns, at several nesting levels and after overflow, and that underflow in both forms is caught.

// File: rtl/divmask_pkg.sv
package divmask_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_OPEN,
    OP_SWITCH,
    OP_CLOSE,
    OP_BAD
  } mask_op_e;
endpackage

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LANES-1:0] push_parent,
  input  logic [LANES-1:0] push_alt,
  output logic [DW-1:0]    depth,
  output logic [LANES-1:0] top_parent,
  output logic [LANES-1:0] top_alt
);
  logic [LANES-1:0] parent_q [DEPTH];
  logic [LANES-1:0] alt_q    [DEPTH];
  logic [DW-1:0]    depth_m1;
  logic [IW-1:0]    top_idx;

  assign depth_m1 = depth - DW'(1);
  assign top_idx  = depth_m1[IW-1:0];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          parent_q[i] <= '1;
          alt_q[i]    <= '0;
        end else if (push && depth == DW'(i)) begin
          parent_q[i] <= push_parent;
          alt_q[i]    <= push_alt;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    depth <= '0;
    else if (push) depth <= depth + DW'(1);
    else if (pop)  depth <= depth - DW'(1);
  end

  assign top_parent = parent_q[top_idx];
  assign top_alt    = alt_q[top_idx];
endmodule

// File: rtl/mask_ctrl.sv
module mask_ctrl
  import divmask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             br_strobe,
  input  logic             else_strobe,
  input  logic             endif_strobe,
  input  logic [LANES-1:0] lane_cond,
  input  logic [LANES-1:0] cur_mask,
  input  logic [DW-1:0]    depth,
  input  logic [LANES-1:0] top_parent,
  input  logic [LANES-1:0] top_alt,
  output mask_op_e         op,
  output logic             push,
  output logic             pop,
  output logic [LANES-1:0] push_alt,
  output logic             mask_we,
  output logic [LANES-1:0] mask_nxt,
  output logic             err_set
);
  logic [1:0] n_strobe;
  logic       full, empty;

  assign n_strobe = {1'b0, br_strobe} + {1'b0, else_strobe} + {1'b0, endif_strobe};
  assign full     = (depth == DW'(DEPTH));
  assign empty    = (depth == '0);
  assign push_alt = cur_mask & ~lane_cond;

  always_comb begin
    op = OP_IDLE;
    if (n_strobe > 2'd1)                   op = OP_BAD;
    else if (br_strobe)                    op = full  ? OP_BAD : OP_OPEN;
    else if (else_strobe)                  op = empty ? OP_BAD : OP_SWITCH;
    else if (endif_strobe)                 op = empty ? OP_BAD : OP_CLOSE;
  end

  always_comb begin
    push     = 1'b0;
    pop      = 1'b0;
    mask_we  = 1'b0;
    mask_nxt = cur_mask;
    err_set  = 1'b0;
    unique case (op)
      OP_OPEN: begin
        push     = 1'b1;
        mask_we  = 1'b1;
        mask_nxt = cur_mask & lane_cond;
      end
      OP_SWITCH: begin
        mask_we  = 1'b1;
        mask_nxt = top_alt;
      end
      OP_CLOSE: begin
        pop      = 1'b1;
        mask_we  = 1'b1;
        mask_nxt = top_parent;
      end
      OP_BAD:  err_set = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/divergence_mask_unit.sv
module divergence_mask_unit
  import divmask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_strobe,
  input  logic             else_strobe,
  input  logic             endif_strobe,
  input  logic [LANES-1:0] lane_cond,
  output logic [LANES-1:0] active_mask,
  output logic             skip_path,
  output logic [DW-1:0]    nest_depth,
  output logic             err_flag
);
  mask_op_e         op;
  logic             push, pop, mask_we, err_set;
  logic [LANES-1:0] push_alt, mask_nxt, top_parent, top_alt;

  mask_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
    .br_strobe    (br_strobe),
    .else_strobe  (else_strobe),
    .endif_strobe (endif_strobe),
    .lane_cond    (lane_cond),
    .cur_mask     (active_mask),
    .depth        (nest_depth),
    .top_parent   (top_parent),
    .top_alt      (top_alt),
    .op           (op),
    .push         (push),
    .pop          (pop),
    .push_alt     (push_alt),
    .mask_we      (mask_we),
    .mask_nxt     (mask_nxt),
    .err_set      (err_set)
  );

  mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .pop         (pop),
    .push_parent (active_mask),
    .push_alt    (push_alt),
    .depth       (nest_depth),
    .top_parent  (top_parent),
    .top_alt     (top_alt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_mask <= '1;
    else if (mask_we) active_mask <= mask_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_flag <= 1'b0;
    else if (err_set) err_flag <= 1'b1;
  end

  assign skip_path = ~|active_mask;
endmodule

// File: rtl/divmask_chk.sv
module divmask_chk #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_strobe,
  input logic             else_strobe,
  input logic             endif_strobe,
  input logic [LANES-1:0] lane_cond,
  input logic [LANES-1:0] active_mask,
  input logic             skip_path,
  input logic [DW-1:0]    nest_depth,
  input logic             err_flag
);
  logic [1:0] n_str;
  assign n_str = {1'b0, br_strobe} + {1'b0, else_strobe} + {1'b0, endif_strobe};

  // R2
  branch_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_strobe && n_str == 2'd1 && nest_depth < DW'(DEPTH)) |=>
      (active_mask == ($past(active_mask) & $past(lane_cond))) &&
      (nest_depth == $past(nest_depth) + DW'(1)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_str == 2'd0) |=> $stable(active_mask) && $stable(nest_depth) && $stable(skip_path));

  // R7
  overflow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_strobe && n_str == 2'd1 && nest_depth == DW'(DEPTH)) |=>
      err_flag && $stable(active_mask) && $stable(nest_depth));

  // R9
  multi_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_str > 2'd1) |=> err_flag && $stable(active_mask) && $stable(nest_depth));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= DW'(DEPTH));

  // R5
  skip_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_path |-> nest_depth != '0);

  // R1
  base_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_depth == '0) |-> (&active_mask));
endmodule

bind divergence_mask_unit divmask_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_divmask_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .br_strobe    (br_strobe),
  .else_strobe  (else_strobe),
  .endif_strobe (endif_strobe),
  .lane_cond    (lane_cond),
  .active_mask  (active_mask),
  .skip_path    (skip_path),
  .nest_depth   (nest_depth),
  .err_flag     (err_flag)
);

// File: tb/tb_divergence_mask_unit.sv
`timescale 1ns/1ps
module tb_divergence_mask_unit;
  localparam int LANES = 8;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       br_strobe = 1'b0, else_strobe = 1'b0, endif_strobe = 1'b0;
  logic [7:0] lane_cond = '0;
  logic [7:0] active_mask;
  logic       skip_path;
  logic [2:0] nest_depth;
  logic       err_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // independent expectation state
  logic [7:0] e_mask;
  int         e_depth;
  logic       e_err;
  logic [7:0] e_par [DEPTH];
  logic [7:0] e_alt [DEPTH];

  always #4 clk = ~clk;

  divergence_mask_unit #(.LANES(LANES), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .br_strobe(br_strobe), .else_strobe(else_strobe),
    .endif_strobe(endif_strobe), .lane_cond(lane_cond), .active_mask(active_mask),
    .skip_path(skip_path), .nest_depth(nest_depth), .err_flag(err_flag));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " mask"},  active_mask, e_mask);
    chk({tag, " depth"}, nest_depth, e_depth);
    chk({tag, " skip R5"}, skip_path, (e_mask == 8'h00));
    chk({tag, " err"},   err_flag, e_err);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    br_strobe = 0; else_strobe = 0; endif_strobe = 0; lane_cond = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    e_mask = 8'hFF; e_depth = 0; e_err = 1'b0;
    #1;
    chk_all("R1 reset");
  endtask

  // apply one cycle of strobes, update expectations from the requirements, compare
  task automatic step(bit b, bit e, bit n, logic [7:0] c, string tag);
    int cnt;
    @(negedge clk);
    br_strobe = b; else_strobe = e; endif_strobe = n; lane_cond = c;
    @(posedge clk);
    #1;
    br_strobe = 0; else_strobe = 0; endif_strobe = 0;
    cnt = int'(b) + int'(e) + int'(n);
    if (cnt > 1) e_err = 1'b1;
    else if (b) begin
      if (e_depth == DEPTH) e_err = 1'b1;
      else begin
        e_par[e_depth] = e_mask;
        e_alt[e_depth] = e_mask & ~c;
        e_mask = e_mask & c;
        e_depth++;
      end
    end else if (e) begin
      if (e_depth == 0) e_err = 1'b1;
      else e_mask = e_alt[e_depth-1];
    end else if (n) begin
      if (e_depth == 0) e_err = 1'b1;
      else begin
        e_depth--;
        e_mask = e_par[e_depth];
      end
    end
    chk_all(tag);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R2 R3 R4: single-level sweep over every condition pattern
    for (int c = 0; c < 256; c++) begin
      step(1, 0, 0, 8'(c), "R2 open");
      step(0, 1, 0, 8'h00, "R3 switch");
      step(0, 1, 0, 8'h00, "R3 switch again");
      step(0, 0, 0, 8'h00, "R11 idle");
      step(0, 0, 1, 8'h00, "R4 close");
    end

    // R6: two-level nesting, inner sweep under varied outer masks
    for (int o = 0; o < 8; o++) begin
      logic [7:0] oc;
      oc = 8'(o * 37 + 5);
      step(1, 0, 0, oc, "R6 outer open");
      for (int c = 0; c < 256; c++) begin
        step(1, 0, 0, 8'(c), "R6 inner open");
        step(0, 1, 0, 8'h00, "R6 inner switch");
        step(0, 0, 1, 8'h00, "R6 inner close");
      end
      step(0, 1, 0, 8'h00, "R6 outer switch");
      step(1, 0, 0, 8'h5A, "R6 inner on false side");
      step(0, 1, 0, 8'h00, "R6 inner switch on false side");
      step(0, 0, 1, 8'h00, "R6 inner close on false side");
      step(0, 0, 1, 8'h00, "R6 outer close");
    end

    // R7: overflow at full depth, then unwind
    step(1, 0, 0, 8'hF7, "R6 d1");
    step(1, 0, 0, 8'h7E, "R6 d2");
    step(1, 0, 0, 8'h3C, "R6 d3");
    step(1, 0, 0, 8'h18, "R6 d4");
    step(1, 0, 0, 8'hFF, "R7 overflow");
    step(0, 1, 0, 8'h00, "R3 switch at d4");
    for (int k = 0; k < 4; k++) step(0, 0, 1, 8'h00, "R4 unwind");
    step(1, 0, 0, 8'h01, "R10 err kept after legal open");
    step(0, 0, 1, 8'h00, "R10 err kept after close");

    // R8: close at depth 0
    do_reset();
    step(0, 0, 1, 8'h00, "R8 close underflow");
    step(1, 0, 0, 8'hC3, "R10 sticky");
    step(0, 0, 1, 8'h00, "R10 sticky close");

    // R8: switch at depth 0
    do_reset();
    step(0, 1, 0, 8'h00, "R8 switch underflow");

    // R9: simultaneous strobes
    do_reset();
    step(1, 0, 0, 8'h0F, "R2 setup");
    step(1, 1, 0, 8'hF0, "R9 open+switch");
    step(0, 1, 1, 8'h00, "R9 switch+close");
    step(1, 1, 1, 8'h00, "R9 all three");
    step(0, 1, 0, 8'h00, "R3 after R9");
    step(0, 0, 1, 8'h00, "R4 after R9");

    // R5: skip when all lanes disabled
    do_reset();
    step(1, 0, 0, 8'h00, "R5 empty true side");
    step(0, 1, 0, 8'h00, "R5 full false side");
    step(1, 0, 0, 8'hFF, "R5 nested none false");
    step(0, 1, 0, 8'h00, "R5 nested empty false");
    step(0, 0, 1, 8'h00, "R4 close");
    step(0, 0, 1, 8'h00, "R4 close");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule